// File: doc/BRIEF.md
# Power-On Thermal Threshold Configuration Capture

This block turns the result of measuring two strap resistors into the configuration of a two-channel over-temperature switch. One strap sets the hot channel's trip temperature. The other sets the warm channel's trip temperature and also the hysteresis that both channels share. A measurement front end, which is outside this block, reports each result as a strobe. The strobe carries an index into a list of 48 standard resistor values and three flags: grounded, floating and out of range.

After reset, each strap is measured again and again. Its result is accepted only when two consecutive results are identical. The accepted codes are then decoded into trip temperatures and hysteresis values in whole degrees Celsius. That configuration is frozen until the next reset. A channel's enable stays low while its strap is still retrying and stays low for good if the strap is illegal. A one-cycle done pulse marks the moment each channel's configuration becomes final. The hot channel's hysteresis depends on the warm strap, so the hot channel becomes final only once the warm strap has settled as well.

Top module: `therm_cfg_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both enables and both done flags are 0, and all trip and hysteresis outputs are 0.
- R2: A result word is packed as {grounded, floating, out-of-range, index[5:0]} (bits 8, 7, 6, 5:0). A strap settles when a result equals the previous result of the same strap in all 9 bits. A mismatching result becomes the new reference.
- R3: A channel's enable is 0 until its done pulse. A settling result clocked in at edge k makes the channel's done flag 1 in the cycle after edge k and 0 in every other cycle. Enable and values change at that same edge.
- R4: A legal hot code has all three flags clear and index i ≤ 47. It gives a hot trip of 30 + 2·i °C and enables the hot channel.
- R5: A hot code with any flag set, or with index 48 to 63, leaves the hot enable at 0 with hot trip and hysteresis 0. The warm channel's decode is unaffected.
- R6: A legal warm code with index i from 16 to 31 gives warm hysteresis 5 °C and a warm trip of 105 − 5·(i − 16) °C.
- R7: A legal warm code with index i from 32 to 47 gives warm hysteresis 10 °C and a warm trip of 30 + 5·(i − 32) °C.
- R8: With a legal warm code and a legal hot code, the hot hysteresis equals the warm hysteresis.
- R9: A warm code that is grounded, floating, out of range, or has an index below 16 or above 47 leaves the warm enable at 0 with trip and hysteresis 0. A legal hot channel then uses 20 °C hysteresis.
- R10: The hot done pulse comes in the cycle after the later of the two settling edges, never before the warm strap has settled.
- R11: Once a strap has settled, its later results are ignored. Configuration outputs and enables hold and no further done pulse occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hotValid | input | 1 | Hot strap result strobe |
| hotIdx | input | 6 | Hot strap resistor index |
| hotGnd | input | 1 | Hot strap reads grounded |
| hotFlt | input | 1 | Hot strap reads floating |
| hotOor | input | 1 | Hot strap reads out of range |
| warmValid | input | 1 | Warm strap result strobe |
| warmIdx | input | 6 | Warm strap resistor index |
| warmGnd | input | 1 | Warm strap reads grounded |
| warmFlt | input | 1 | Warm strap reads floating |
| warmOor | input | 1 | Warm strap reads out of range |
| hotEn | output | 1 | Hot channel enabled (configuration final and legal) |
| hotTrip | output | 8 | Hot trip temperature, °C |
| hotHyst | output | 5 | Hot hysteresis, °C |
| hotDone | output | 1 | One-cycle pulse when hot configuration becomes final |
| warmEn | output | 1 | Warm channel enabled |
| warmTrip | output | 8 | Warm trip temperature, °C |
| warmHyst | output | 5 | Warm hysteresis, °C |
| warmDone | output | 1 | One-cycle pulse when warm configuration becomes final |

## Verification
The hardest case to reach is the hot channel settling first while the warm strap keeps mismatching. In that case the hot configuration must wait and then pick up a hysteresis that arrives later. Reaching it requires ordering the two straps and inserting decoy results. Each trial therefore picks at random which strap goes first, and whether a strap sees a differing decoy before its repeated code. After the random trials, directed trials cover both index boundaries of each warm band, the hot range limits, and every kind of illegal warm strap. The trials end by sending fresh results once both straps are frozen, to show that they are ignored.

// File: rtl/therm_cfg_pkg.sv
package therm_cfg_pkg;
  localparam int IDX_W        = 6;
  localparam int TEMP_W       = 8;
  localparam int HYST_W       = 5;
  localparam int CODE_COUNT   = 48;
  localparam int HOT_BASE     = 30;
  localparam int HOT_STEP     = 2;
  localparam int WARM_FIRST   = 16;
  localparam int WARM_SPLIT   = 32;
  localparam int WARM_HI_TOP  = 105;
  localparam int WARM_LO_BASE = 30;
  localparam int WARM_STEP    = 5;
  localparam int HYST_NARROW  = 5;
  localparam int HYST_WIDE    = 10;
  localparam int HYST_SOLO    = 20;

  typedef struct packed {
    logic             gnd;
    logic             flt;
    logic             oor;
    logic [IDX_W-1:0] idx;
  } measT;

  typedef struct packed {
    logic loadHot;
    logic loadWarm;
    logic commitHot;
    logic commitWarm;
  } strobeT;

  function automatic logic hotLegal(measT m);
    return !m.gnd && !m.flt && !m.oor && (int'(m.idx) < CODE_COUNT);
  endfunction

  function automatic logic warmLegal(measT m);
    return hotLegal(m) && (int'(m.idx) >= WARM_FIRST);
  endfunction

  function automatic logic [TEMP_W-1:0] hotTripOf(measT m);
    int t;
    t = HOT_BASE + HOT_STEP * int'(m.idx);
    return TEMP_W'(t);
  endfunction

  function automatic logic [TEMP_W-1:0] warmTripOf(measT m);
    int i;
    int t;
    i = int'(m.idx);
    if (i < WARM_SPLIT) t = WARM_HI_TOP - WARM_STEP * (i - WARM_FIRST);
    else                t = WARM_LO_BASE + WARM_STEP * (i - WARM_SPLIT);
    return TEMP_W'(t);
  endfunction

  function automatic logic [HYST_W-1:0] warmHystOf(measT m);
    return (int'(m.idx) < WARM_SPLIT) ? HYST_W'(HYST_NARROW) : HYST_W'(HYST_WIDE);
  endfunction
endpackage

// File: rtl/therm_cfg_ctrl.sv
module therm_cfg_ctrl
  import therm_cfg_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   hotValid,
  input  logic   warmValid,
  input  logic   hotMatch,
  input  logic   warmMatch,
  output strobeT strobe
);
  localparam int HOT  = 0;
  localparam int WARM = NUM_PINS - 1;

  logic [NUM_PINS-1:0] valid, match, havePrev, settled, settleNow, loadNow;
  logic hotFinal;

  assign valid = {warmValid, hotValid};
  assign match = {warmMatch, hotMatch};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign settleNow[p] = valid[p] && havePrev[p] && match[p] && !settled[p];
    assign loadNow[p]   = valid[p] && !settled[p];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        havePrev[p] <= 1'b0;
        settled[p]  <= 1'b0;
      end else begin
        if (loadNow[p])   havePrev[p] <= 1'b1;
        if (settleNow[p]) settled[p]  <= 1'b1;
      end
    end
  end

  logic hotReady, warmReady;
  assign hotReady  = settled[HOT]  || settleNow[HOT];
  assign warmReady = settled[WARM] || settleNow[WARM];

  always_comb begin
    strobe            = '0;
    strobe.loadHot    = loadNow[HOT];
    strobe.loadWarm   = loadNow[WARM];
    strobe.commitWarm = settleNow[WARM];
    strobe.commitHot  = !hotFinal && hotReady && warmReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 hotFinal <= 1'b0;
    else if (strobe.commitHot) hotFinal <= 1'b1;
  end
endmodule

// File: rtl/therm_cfg_dpath.sv
module therm_cfg_dpath
  import therm_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  measT              hotMeas,
  input  measT              warmMeas,
  input  strobeT            strobe,
  output logic              hotMatch,
  output logic              warmMatch,
  output logic              hotEn,
  output logic [TEMP_W-1:0] hotTrip,
  output logic [HYST_W-1:0] hotHyst,
  output logic              hotDone,
  output logic              warmEn,
  output logic [TEMP_W-1:0] warmTrip,
  output logic [HYST_W-1:0] warmHyst,
  output logic              warmDone
);
  measT prevHot, prevWarm;

  assign hotMatch  = (hotMeas == prevHot);
  assign warmMatch = (warmMeas == prevWarm);

  logic              hotOk, warmOk;
  logic [HYST_W-1:0] sharedHyst;
  assign hotOk      = hotLegal(prevHot);
  assign warmOk     = warmLegal(prevWarm);
  assign sharedHyst = warmOk ? warmHystOf(prevWarm) : HYST_W'(HYST_SOLO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHot  <= '0;
      prevWarm <= '0;
      hotEn    <= 1'b0;
      hotTrip  <= '0;
      hotHyst  <= '0;
      hotDone  <= 1'b0;
      warmEn   <= 1'b0;
      warmTrip <= '0;
      warmHyst <= '0;
      warmDone <= 1'b0;
    end else begin
      if (strobe.loadHot)  prevHot  <= hotMeas;
      if (strobe.loadWarm) prevWarm <= warmMeas;
      hotDone  <= strobe.commitHot;
      warmDone <= strobe.commitWarm;
      if (strobe.commitHot) begin
        hotEn   <= hotOk;
        hotTrip <= hotOk ? hotTripOf(prevHot) : '0;
        hotHyst <= hotOk ? sharedHyst : '0;
      end
      if (strobe.commitWarm) begin
        warmEn   <= warmLegal(warmMeas);
        warmTrip <= warmLegal(warmMeas) ? warmTripOf(warmMeas) : '0;
        warmHyst <= warmLegal(warmMeas) ? warmHystOf(warmMeas) : '0;
      end
    end
  end
endmodule

// File: rtl/therm_cfg_capture.sv
module therm_cfg_capture
  import therm_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hotValid,
  input  logic [IDX_W-1:0]  hotIdx,
  input  logic              hotGnd,
  input  logic              hotFlt,
  input  logic              hotOor,
  input  logic              warmValid,
  input  logic [IDX_W-1:0]  warmIdx,
  input  logic              warmGnd,
  input  logic              warmFlt,
  input  logic              warmOor,
  output logic              hotEn,
  output logic [TEMP_W-1:0] hotTrip,
  output logic [HYST_W-1:0] hotHyst,
  output logic              hotDone,
  output logic              warmEn,
  output logic [TEMP_W-1:0] warmTrip,
  output logic [HYST_W-1:0] warmHyst,
  output logic              warmDone
);
  measT   hotMeas, warmMeas;
  strobeT strobe;
  logic   hotMatch, warmMatch;

  assign hotMeas  = '{gnd: hotGnd,  flt: hotFlt,  oor: hotOor,  idx: hotIdx};
  assign warmMeas = '{gnd: warmGnd, flt: warmFlt, oor: warmOor, idx: warmIdx};

  therm_cfg_ctrl #(.NUM_PINS(2)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hotValid(hotValid), .warmValid(warmValid),
    .hotMatch(hotMatch), .warmMatch(warmMatch),
    .strobe(strobe)
  );

  therm_cfg_dpath u_dpath (
    .clk(clk), .rstN(rstN),
    .hotMeas(hotMeas), .warmMeas(warmMeas), .strobe(strobe),
    .hotMatch(hotMatch), .warmMatch(warmMatch),
    .hotEn(hotEn), .hotTrip(hotTrip), .hotHyst(hotHyst), .hotDone(hotDone),
    .warmEn(warmEn), .warmTrip(warmTrip), .warmHyst(warmHyst), .warmDone(warmDone)
  );
endmodule

// File: rtl/therm_cfg_capture_chk.sv
module therm_cfg_capture_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hotEn,
  input logic [7:0] hotTrip,
  input logic [4:0] hotHyst,
  input logic       hotDone,
  input logic       warmEn,
  input logic [7:0] warmTrip,
  input logic [4:0] warmHyst,
  input logic       warmDone
);
  logic hotSeen, warmSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hotSeen  <= 1'b0;
      warmSeen <= 1'b0;
    end else begin
      if (hotDone)  hotSeen  <= 1'b1;
      if (warmDone) warmSeen <= 1'b1;
    end
  end

  AST_HOT_HELD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!hotSeen && !hotDone) |-> !hotEn); // R3
  AST_WARM_HELD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!warmSeen && !warmDone) |-> !warmEn); // R3
  AST_HOT_TRIP_GRID: assert property (@(posedge clk) disable iff (!rstN)
    hotEn |-> (hotTrip >= 8'd30 && hotTrip <= 8'd124 && !hotTrip[0])); // R4
  AST_HOT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hotEn |-> (hotTrip == 8'd0 && hotHyst == 5'd0)); // R5
  AST_WARM_HYST_SET: assert property (@(posedge clk) disable iff (!rstN)
    warmEn |-> (warmHyst == 5'd5 || warmHyst == 5'd10)); // R7
  AST_SHARED_HYST: assert property (@(posedge clk) disable iff (!rstN)
    (hotEn && warmEn) |-> (hotHyst == warmHyst)); // R8
  AST_HOT_AFTER_WARM: assert property (@(posedge clk) disable iff (!rstN)
    hotDone |-> (warmDone || warmSeen)); // R10
  AST_HOT_DONE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    hotSeen |-> !hotDone); // R11
  AST_WARM_DONE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    warmSeen |-> !warmDone); // R11
  AST_HOT_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    hotSeen |-> ($stable(hotEn) && $stable(hotTrip) && $stable(hotHyst))); // R11
  AST_WARM_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    warmSeen |-> ($stable(warmEn) && $stable(warmTrip) && $stable(warmHyst))); // R11
endmodule

bind therm_cfg_capture therm_cfg_capture_chk u_chk (
  .clk(clk), .rstN(rstN),
  .hotEn(hotEn), .hotTrip(hotTrip), .hotHyst(hotHyst), .hotDone(hotDone),
  .warmEn(warmEn), .warmTrip(warmTrip), .warmHyst(warmHyst), .warmDone(warmDone)
);

// File: tb/therm_cfg_capture_bench.sv
module therm_cfg_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hotValid = 1'b0, warmValid = 1'b0;
  logic [5:0] hotIdx = '0, warmIdx = '0;
  logic hotGnd = 0, hotFlt = 0, hotOor = 0, warmGnd = 0, warmFlt = 0, warmOor = 0;
  logic hotEn, hotDone, warmEn, warmDone;
  logic [7:0] hotTrip, warmTrip;
  logic [4:0] hotHyst, warmHyst;

  int checks = 0;
  int fails  = 0;
  bit hotSet, warmSet, hotFin;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_cfg_capture u_therm_cfg_capture (
    .clk(clk), .rstN(rstN),
    .hotValid(hotValid), .hotIdx(hotIdx), .hotGnd(hotGnd), .hotFlt(hotFlt), .hotOor(hotOor),
    .warmValid(warmValid), .warmIdx(warmIdx), .warmGnd(warmGnd), .warmFlt(warmFlt), .warmOor(warmOor),
    .hotEn(hotEn), .hotTrip(hotTrip), .hotHyst(hotHyst), .hotDone(hotDone),
    .warmEn(warmEn), .warmTrip(warmTrip), .warmHyst(warmHyst), .warmDone(warmDone)
  );

  // code word: bit8 grounded, bit7 floating, bit6 out of range, bits5:0 index
  function automatic bit hotOkE(logic [8:0] c);
    return c[8:6] == 3'b000 && c[5:0] < 6'd48;
  endfunction
  function automatic bit warmOkE(logic [8:0] c);
    return hotOkE(c) && c[5:0] >= 6'd16;
  endfunction
  function automatic int hotTripE(logic [8:0] c);
    return hotOkE(c) ? 30 + 2 * int'(c[5:0]) : 0;
  endfunction
  function automatic int warmTripE(logic [8:0] c);
    if (!warmOkE(c)) return 0;
    if (c[5:0] < 6'd32) return 105 - 5 * (int'(c[5:0]) - 16);
    return 30 + 5 * (int'(c[5:0]) - 32);
  endfunction
  function automatic int warmHystE(logic [8:0] c);
    if (!warmOkE(c)) return 0;
    return (c[5:0] < 6'd32) ? 5 : 10;
  endfunction
  function automatic int hotHystE(logic [8:0] h, logic [8:0] w);
    if (!hotOkE(h)) return 0;
    return warmOkE(w) ? warmHystE(w) : 20;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; hotValid = 1'b0; warmValid = 1'b0;
    @(negedge clk);
    chk("R1", "hotEn in reset", int'(hotEn), 0);
    chk("R1", "warmDone in reset", int'(warmDone), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "hotEn", int'(hotEn), 0);
    chk("R1", "warmEn", int'(warmEn), 0);
    chk("R1", "hotDone", int'(hotDone), 0);
    chk("R1", "warmDone", int'(warmDone), 0);
    chk("R1", "hotTrip", int'(hotTrip), 0);
    chk("R1", "warmHyst", int'(warmHyst), 0);
    hotSet = 0; warmSet = 0; hotFin = 0;
  endtask

  task automatic measure(bit warm, logic [8:0] c);
    @(negedge clk);
    if (warm) begin
      warmValid = 1'b1; {warmGnd, warmFlt, warmOor, warmIdx} = c;
    end else begin
      hotValid = 1'b1; {hotGnd, hotFlt, hotOor, hotIdx} = c;
    end
    @(negedge clk);
    hotValid = 1'b0; warmValid = 1'b0;
  endtask

  task automatic checkState(logic [8:0] h, logic [8:0] w, bit expHD, bit expWD, string req);
    chk(req, "hotDone", int'(hotDone), int'(expHD));
    chk(req, "warmDone", int'(warmDone), int'(expWD));
    chk("R3", "hotEn", int'(hotEn), hotFin ? int'(hotOkE(h)) : 0);
    chk("R3", "warmEn", int'(warmEn), warmSet ? int'(warmOkE(w)) : 0);
    if (hotFin) begin
      chk(hotOkE(h) ? "R4" : "R5", "hotTrip", int'(hotTrip), hotTripE(h));
      chk(warmOkE(w) ? "R8" : "R9", "hotHyst", int'(hotHyst), hotHystE(h, w));
    end
    if (warmSet) begin
      chk(warmOkE(w) ? (w[5:0] < 6'd32 ? "R6" : "R7") : "R9", "warmTrip", int'(warmTrip), warmTripE(w));
      chk(warmOkE(w) ? (w[5:0] < 6'd32 ? "R6" : "R7") : "R9", "warmHyst", int'(warmHyst), warmHystE(w));
    end
  endtask

  task automatic settlePin(bit warm, logic [8:0] h, logic [8:0] w, bit decoy, logic [8:0] mask);
    logic [8:0] c;
    bit expH;
    c = warm ? w : h;
    if (decoy) begin
      measure(warm, c ^ mask);
      checkState(h, w, 0, 0, "R2");
    end
    measure(warm, c);
    checkState(h, w, 0, 0, "R2");
    measure(warm, c);
    if (warm) warmSet = 1; else hotSet = 1;
    expH = hotSet && warmSet && !hotFin;
    if (expH) hotFin = 1;
    checkState(h, w, expH, warm, "R10");
  endtask

  task automatic trial(logic [8:0] h, logic [8:0] w, bit warmFirst, bit dH, bit dW);
    logic [8:0] mask;
    mask = 9'(1 + ($urandom % 511));
    doReset();
    settlePin(warmFirst, h, w, warmFirst ? dW : dH, mask);
    settlePin(!warmFirst, h, w, warmFirst ? dH : dW, mask);
    for (int k = 0; k < 2; k++) begin
      measure(1'b0, h ^ mask);
      checkState(h, w, 0, 0, "R11");
      measure(1'b1, w ^ mask);
      checkState(h, w, 0, 0, "R11");
    end
  endtask

  function automatic logic [8:0] randHot();
    int r;
    r = $urandom % 10;
    if (r < 7)  return {3'b000, 6'($urandom % 48)};
    if (r == 7) return {3'b000, 6'(48 + $urandom % 16)};
    if (r == 8) return {3'b001 << ($urandom % 3), 6'($urandom % 64)};
    return 9'h100;
  endfunction

  function automatic logic [8:0] randWarm();
    int r;
    r = $urandom % 10;
    if (r < 6)  return {3'b000, 6'(16 + $urandom % 32)};
    if (r == 6) return {3'b000, 6'($urandom % 16)};
    if (r == 7) return {3'b000, 6'(48 + $urandom % 16)};
    return {3'b001 << ($urandom % 3), 6'($urandom % 64)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // directed corners
    trial({3'b000, 6'd0},  {3'b000, 6'd16}, 1, 0, 0);  // R4 lowest hot, R6 top of narrow band
    trial({3'b000, 6'd47}, {3'b000, 6'd31}, 0, 1, 0);  // R4 highest hot, R6 bottom
    trial({3'b000, 6'd30}, {3'b000, 6'd32}, 0, 1, 1);  // R7 lowest wide
    trial({3'b000, 6'd10}, {3'b000, 6'd47}, 1, 0, 1);  // R7 highest wide
    trial({3'b000, 6'd5},  9'h100, 0, 0, 1);           // R9 warm grounded
    trial({3'b000, 6'd6},  9'h080, 1, 1, 0);           // R9 warm floating
    trial({3'b000, 6'd7},  {3'b000, 6'd15}, 0, 0, 0);  // R9 warm index too low
    trial({3'b000, 6'd8},  9'h040 | 9'd20, 1, 0, 0);   // R9 warm out of range
    trial({3'b000, 6'd48}, {3'b000, 6'd40}, 0, 1, 0);  // R5 hot index too high
    trial(9'h100,          {3'b000, 6'd20}, 0, 0, 1);  // R5 hot grounded
    trial(9'h080 | 9'd3,   {3'b000, 6'd36}, 1, 1, 1);  // R5 hot floating
    for (int t = 0; t < 60; t++)
      trial(randHot(), randWarm(), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule